// File: doc/BRIEF.md
# Per-Bit Mode Control Output Register

This block is an eight-bit control register that software writes over a simple register bus. Its value drives eight control lines into the surrounding logic. Two mode registers give each line its own 2-bit mode, so each bit can follow its stored value in one of three ways:

- **Direct:** the bit tracks the written value at once.
- **Synchronized:** the bit is resampled only when a slower sampling enable pulses.
- **Pulse:** a written 1 becomes one high output lasting a full sampling period, and the stored bit then clears itself.

A routed external reset line can clear the output stages. A configuration bit decides whether that reset also clears the stored register bits.

Each bit holds a small pulse state machine with three states:

- **ST_IDLE:** nothing is pending.
- **ST_ARMED:** a 1 is stored and waits for a sampling edge.
- **ST_FIRE:** the output is high.

The transitions are as follows:

- **arm:** ST_IDLE goes to ST_ARMED when the stored bit is 1 and no sampling edge is allowed.
- **launch:** ST_IDLE or ST_ARMED goes to ST_FIRE on a sampling edge while the stored bit is 1 and the external reset is low.
- **expire:** ST_FIRE goes to ST_IDLE on the next sampling edge, and the stored bit clears.
- **abort:** ST_FIRE goes back to ST_ARMED on an external reset when the reset does not reach the stored bits.
- **flush:** any state goes to ST_IDLE on an external reset that does reach the stored bits, or whenever the bit is not in pulse mode.

Top module: `ctl_out_reg`

## Requirements
- R1: After the asynchronous reset (rst_n low), the stored bits, both mode registers, the reset-reach bit and ctl_out are all 0.
- R2: Bus addresses are 0 for the stored control bits, 1 for the low mode bits, 2 for the high mode bits, and 3 for the reset-reach bit (data bit 0). bus_rdata shows the register selected by bus_addr, and the reach register reads back in bit 0. The mode of bit i is {high[i], low[i]}: 00 is direct, 01 is synchronized, 10 is reserved, 11 is pulse.
- R3: In direct mode, ctl_out[i] equals bus_wdata[i] in the same cycle as a write to address 0, and holds the stored bit afterwards.
- R4: In synchronized mode, ctl_out[i] changes only at a clock edge where smp_en is 1, and then takes the stored bit.
- R5: In pulse mode, a written 1 drives ctl_out[i] high from the first smp_en edge after the write until the next smp_en edge, and then low.
- R6: In pulse mode, the stored bit reads back as 1 from the write until the pulse ends, and as 0 after that.
- R7: With the reach bit at 0, an ext_rst cycle clears the synchronized and pulse outputs but leaves the stored bits unchanged.
- R8: With the reach bit at 1, an ext_rst cycle clears the stored bits as well as the outputs. The mode registers are not affected.
- R9: Mode code 10 behaves exactly like direct mode.
- R10: In pulse mode, any write to a bit whose pulse is pending (armed or firing) is ignored: the pulse is neither lengthened nor cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sampling enable, one cycle high per sampling period |
| ext_rst | input | 1 | Routed external reset, synchronous, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select for write and read-back |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read-back of the selected register |
| ctl_out | output | 8 | Control lines |

## Verification
On every cycle, the assertions check the following:

- A synchronized output holds between sampling enables.
- A firing pulse ends at the next sampling edge.
- A pending pulse always has its stored bit set.
- A pending pulse ignores writes.
- An external reset leaves the output stages low.
- A deep reset empties the stored bits.

Other behaviours can only be shown by the bench's scenarios:

- The same-cycle bypass in direct and reserved modes.
- The exact starting edge and the full-period length of a pulse.
- Read-back through the bus.
- The difference between the two reset reaches, seen at the ports.

// File: rtl/ctl_out_pkg.sv
package ctl_out_pkg;

    typedef enum logic [1:0] {
        MD_DIRECT = 2'b00,
        MD_SYNC   = 2'b01,
        MD_RSVD   = 2'b10,
        MD_PULSE  = 2'b11
    } bit_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_FIRE  = 2'b10
    } pulse_st_e;

    localparam int          ADDR_W = 2;
    localparam logic [1:0]  A_CTL  = 2'd0;
    localparam logic [1:0]  A_MLO  = 2'd1;
    localparam logic [1:0]  A_MHI  = 2'd2;
    localparam logic [1:0]  A_CFG  = 2'd3;

endpackage

// File: rtl/ctl_cfg_regs.sv
module ctl_cfg_regs
    import ctl_out_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      mode_lo,
    output logic [W-1:0]      mode_hi,
    output logic              reach
);

    // Mode and reach registers; the external reset never touches these.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_lo <= '0;
            mode_hi <= '0;
            reach   <= 1'b0;
        end else if (wr) begin
            unique case (addr)
                A_MLO:   mode_lo <= wdata;
                A_MHI:   mode_hi <= wdata;
                A_CFG:   reach   <= wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctl_bit_cell.sv
module ctl_bit_cell
    import ctl_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       smp_en,
    input  logic       ext_rst,
    input  logic       reach,
    input  logic       wr,
    input  logic       wbit,
    output logic       stored,
    output logic       out
);

    bit_mode_e md;
    pulse_st_e st, st_nx;
    logic      is_pulse, is_sync, deep_rst, fire_ok, o_sync;

    assign md       = bit_mode_e'(mode);
    assign is_pulse = (md == MD_PULSE);
    assign is_sync  = (md == MD_SYNC);
    assign deep_rst = ext_rst && reach;
    assign fire_ok  = smp_en && !ext_rst;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        if (!is_pulse || deep_rst) begin
            st_nx = ST_IDLE;                        // flush
        end else begin
            unique case (st)
                ST_IDLE:  if (stored) st_nx = fire_ok ? ST_FIRE : ST_ARMED;
                ST_ARMED: if (fire_ok) st_nx = ST_FIRE;   // launch
                ST_FIRE: begin
                    if (ext_rst)     st_nx = ST_ARMED;    // abort
                    else if (smp_en) st_nx = ST_IDLE;     // expire
                end
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // Stored bit: pending pulses lock out writes, expiry clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored <= 1'b0;
        end else if (deep_rst) begin
            stored <= 1'b0;
        end else if (is_pulse) begin
            if (st == ST_FIRE && fire_ok) stored <= 1'b0;
            else if (wr && !stored)       stored <= wbit;
        end else if (wr) begin
            stored <= wbit;
        end
    end

    // Synchronized output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      o_sync <= 1'b0;
        else if (ext_rst) o_sync <= 1'b0;
        else if (smp_en)  o_sync <= stored;
    end

    // Output select
    always_comb begin
        unique case (md)
            MD_SYNC:  out = o_sync;
            MD_PULSE: out = (st == ST_FIRE);
            default:  out = wr ? wbit : stored;   // direct and reserved
        endcase
    end

    p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sync && $past(is_sync) && !$past(smp_en) && !$past(ext_rst)) |-> $stable(out));

    p_fire_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pulse && st == ST_FIRE && smp_en && !ext_rst) |=> (st != ST_FIRE));

    p_pending_reads_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pulse && st != ST_IDLE) |-> stored);

    p_ext_out_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_sync || is_pulse) && $past(ext_rst) && $past(md) == md) |-> !out);

    p_deep_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deep_rst |=> !stored);

    p_no_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pulse && stored && !ext_rst && !(st == ST_FIRE && smp_en)) |=> stored);

endmodule

// File: rtl/ctl_out_reg.sv
module ctl_out_reg
    import ctl_out_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic              ext_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic [W-1:0]      ctl_out
);

    logic [W-1:0] mode_lo, mode_hi, stored;
    logic         reach, ctl_wr;

    assign ctl_wr = bus_wr && (bus_addr == A_CTL);

    ctl_cfg_regs #(.W(W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .mode_lo (mode_lo),
        .mode_hi (mode_hi),
        .reach   (reach)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        ctl_bit_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    ({mode_hi[i], mode_lo[i]}),
            .smp_en  (smp_en),
            .ext_rst (ext_rst),
            .reach   (reach),
            .wr      (ctl_wr),
            .wbit    (bus_wdata[i]),
            .stored  (stored[i]),
            .out     (ctl_out[i])
        );
    end

    always_comb begin
        unique case (bus_addr)
            A_CTL:   bus_rdata = stored;
            A_MLO:   bus_rdata = mode_lo;
            A_MHI:   bus_rdata = mode_hi;
            default: bus_rdata = {{(W-1){1'b0}}, reach};
        endcase
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (stored == '0 && mode_lo == '0 && mode_hi == '0));

endmodule

// File: tb/sim_ctl_out_reg.sv
module sim_ctl_out_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic       ext_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, ctl_out;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    ctl_out_reg u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .ext_rst(ext_rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ctl_out(ctl_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata; bus_addr = 2'd0;
    endtask

    task automatic sample_tick();
        smp_en = 1'b1; @(negedge clk); smp_en = 1'b0;
    endtask

    task automatic ext_tick();
        ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 ctl_out", ctl_out, 8'h00);
        read_reg(2'd0, d); check("R1 stored", d, 8'h00);
        read_reg(2'd1, d); check("R1 mode lo", d, 8'h00);
        read_reg(2'd2, d); check("R1 mode hi", d, 8'h00);
        read_reg(2'd3, d); check("R1 reach", d, 8'h00);
    endtask

    task automatic t_direct();
        logic [7:0] d;
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hA5; #1;
        check("R3 same-cycle out", ctl_out, 8'hA5);
        @(negedge clk); bus_wr = 1'b0;
        check("R3 held out", ctl_out, 8'hA5);
        read_reg(2'd0, d); check("R2 ctl readback", d, 8'hA5);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        wr_reg(2'd2, 8'h01);          // bit0 -> code 10
        read_reg(2'd2, d); check("R2 mode hi readback", d, 8'h01);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h5A; #1;
        check("R9 reserved acts direct", ctl_out, 8'h5A);
        @(negedge clk); bus_wr = 1'b0;
        wr_reg(2'd2, 8'h00);
    endtask

    task automatic t_sync();
        wr_reg(2'd1, 8'hFF);          // all synchronized
        wr_reg(2'd0, 8'h3C);
        step(2);
        check("R4 no update without smp_en", ctl_out, 8'h00);
        sample_tick();
        check("R4 updated on smp_en", ctl_out, 8'h3C);
        wr_reg(2'd0, 8'hC3);
        step(2);
        check("R4 holds between samples", ctl_out, 8'h3C);
        wr_reg(2'd0, 8'h00);
    endtask

    task automatic t_pulse();
        logic [7:0] d;
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'hFF);          // all pulse
        wr_reg(2'd0, 8'h81);
        read_reg(2'd0, d); check("R6 pending reads 1", d, 8'h81);
        step(2);
        check("R5 no output before sample", ctl_out, 8'h00);
        sample_tick();
        check("R5 pulse starts", ctl_out, 8'h81);
        step(3);
        check("R5 pulse lasts full period", ctl_out, 8'h81);
        wr_reg(2'd0, 8'h81);
        wr_reg(2'd0, 8'h00);
        read_reg(2'd0, d); check("R10 writes ignored while firing", d, 8'h81);
        sample_tick();
        check("R5 pulse ends", ctl_out, 8'h00);
        read_reg(2'd0, d); check("R6 cleared after pulse", d, 8'h00);
        wr_reg(2'd0, 8'h02);
        wr_reg(2'd0, 8'h00);
        read_reg(2'd0, d); check("R10 armed bit not cancelled", d, 8'h02);
        sample_tick();
        check("R10 armed pulse fires", ctl_out, 8'h02);
        sample_tick();
        check("R10 not lengthened", ctl_out, 8'h00);
    endtask

    task automatic t_ext_shallow();
        logic [7:0] d;
        wr_reg(2'd2, 8'h00);          // all synchronized
        wr_reg(2'd0, 8'hFF);
        sample_tick();
        check("R7 setup", ctl_out, 8'hFF);
        ext_tick();
        check("R7 output cleared", ctl_out, 8'h00);
        read_reg(2'd0, d); check("R7 stored kept", d, 8'hFF);
        sample_tick();
        check("R7 output restored", ctl_out, 8'hFF);
    endtask

    task automatic t_ext_deep();
        logic [7:0] d;
        wr_reg(2'd3, 8'h01);
        wr_reg(2'd1, 8'h7F);          // bit7 direct, rest synchronized
        read_reg(2'd3, d); check("R2 reach readback", d, 8'h01);
        check("R8 setup", ctl_out, 8'hFF);
        ext_tick();
        check("R8 outputs cleared", ctl_out, 8'h00);
        read_reg(2'd0, d); check("R8 stored cleared", d, 8'h00);
        read_reg(2'd1, d); check("R8 mode kept", d, 8'h7F);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_direct();
        t_reserved();
        t_sync();
        t_pulse();
        t_ext_shallow();
        t_ext_deep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule